// File: doc/BRIEF.md
# Push-Pull Two-Wire Serial Target

This block is the target end of a point-to-point serial link that uses two-wire framing: a start condition, an address byte, data bytes each followed by an acknowledge slot, and a stop condition. Both lines are push-pull. The controller always owns the clock line. The data line is shared by taking turns. The target receives the line samples, brings them into its own clock domain and decodes the framing. It produces the data-line level together with an explicit output enable, and it reaches a register file through a single-cycle read/write strobe port.

Because nothing on the line is open-drain, a level that nobody drives is held by a keeper. The enable rules are what keep the two drivers apart. The target may drive only while the clock line is low. It must let go as soon as the clock rises, and it stays quiet whenever the link is idle. A write transfer loads an internal byte pointer from its first data byte and then stores the following bytes at successive pointer values. A read transfer returns bytes from successive pointer values until the controller declines to acknowledge.

Top module: `pp2w_target`

## Requirements
- R1: During reset and in the first cycle after it, `sda_oe`, `reg_wr` and `reg_rd` are all low.
- R2: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. A stop at any point, including in the middle of a byte, returns the target to idle with `sda_oe` low, and the next start is decoded from scratch.
- R3: `sda_oe` is high only while the synchronised clock line is low. With the default two-stage synchroniser, it is low again by the second rising system-clock edge after the clock pin rises.
- R4: The first byte after a start carries a 7-bit address, most significant bit first, followed by a direction bit (1 = read, 0 = write). The target acknowledges by driving the data line low through the ninth clock only when the address equals `dev_addr`.
- R5: When the address does not match, the target never asserts `sda_oe`, issues no strobe and ignores every byte until the next start.
- R6: In a write transfer, the first data byte is acknowledged and loaded into the byte pointer without a write strobe.
- R7: Each later written byte is acknowledged and causes one cycle of `reg_wr`, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments and wraps modulo 2^PTR_W.
- R8: In a read transfer, each byte is fetched with one cycle of `reg_rd`, with `reg_rdata` sampled in that same cycle. The byte is sent most significant bit first, and the pointer then increments and wraps.
- R9: After each read byte, a low data line in the acknowledge slot continues the transfer. A high level ends it, and the target then does not drive again until the next start.
- R10: A repeated start returns to the address phase, and the pointer keeps its value across starts and stops.
- R11: With the default synchroniser, after the clock pin falls into a slot the target owns, `sda_oe` rises together with the valid bit on the third rising system-clock edge and not before.
- R12: While `sda_oe` is low, `sda_o` keeps the level it last drove, which is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Clock line from the controller |
| sda_i | input | 1 | Data line as seen at the pin |
| dev_addr | input | 7 | Address this target answers to |
| sda_oe | output | 1 | Target data-line driver enable |
| sda_o | output | 1 | Target data-line level, kept while not driving |
| reg_addr | output | PTR_W | Byte pointer presented to the register file |
| reg_wdata | output | 8 | Byte to store |
| reg_wr | output | 1 | One-cycle store strobe |
| reg_rd | output | 1 | One-cycle fetch strobe, `reg_rdata` sampled in the same cycle |
| reg_rdata | input | 8 | Fetched byte |

## Verification
All 128 address values are swept. Only the configured one may be acknowledged, so a comparator that is off by one bit, or that includes the direction bit, gives a wrong acknowledge on some sweep point. The line model includes a keeper, and acknowledges are judged from the enable rather than from the line level, so a design that stays silent cannot pass just because the line still holds the low level the controller left on it. Enable timing is checked exactly at both clock edges: a driver that lingers into the high phase shows up as a clash, and one that comes up early or late misses its fixed edge. Bursts that cross the top of the pointer range, a repeated start, an aborted byte and a read cut short by a refused acknowledge catch pointer wrap errors, pointer reloads, stale state and a target that keeps talking after it is refused.

// File: rtl/pp2w_pkg.sv
package pp2w_pkg;

    localparam int HDR_W  = 8;
    localparam int TADR_W = 7;

    // Protocol phases of the target
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } link_state_e;

    // Line events decoded from the synchronised samples
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_evt_t;

    function automatic logic addr_hit(input logic [HDR_W-1:0] hdr,
                                      input logic [TADR_W-1:0] own);
        return hdr[HDR_W-1:1] == own;
    endfunction

    function automatic logic hdr_is_read(input logic [HDR_W-1:0] hdr);
        return hdr[0];
    endfunction

endpackage

// File: rtl/pp2w_line_sync.sv
module pp2w_line_sync
    import pp2w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt,
    output logic      scl_lvl,
    output logic      scl_prev
);

    localparam int LINES   = 2;
    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [LINES-1:0] pin_raw;
    logic [LINES-1:0] pin_sync;
    logic [LINES-1:0] pin_prev_q;

    assign pin_raw = {scl_i, sda_i};

    // One synchroniser chain per line; both idle high
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], pin_raw[g]};
            end
        end
        assign pin_sync[g] = chain_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev_q <= '1;
        end else begin
            pin_prev_q <= pin_sync;
        end
    end

    logic scl_now, sda_now, scl_was, sda_was;
    assign scl_now = pin_sync[IDX_SCL];
    assign sda_now = pin_sync[IDX_SDA];
    assign scl_was = pin_prev_q[IDX_SCL];
    assign sda_was = pin_prev_q[IDX_SDA];

    always_comb begin
        evt.scl_rise = scl_now & ~scl_was;
        evt.scl_fall = ~scl_now & scl_was;
        evt.start    = scl_now & scl_was & sda_was & ~sda_now;
        evt.stop     = scl_now & scl_was & ~sda_was & sda_now;
        evt.sda      = sda_now;
    end

    assign scl_lvl  = scl_now;
    assign scl_prev = scl_was;

endmodule

// File: rtl/pp2w_proto.sv
module pp2w_proto
    import pp2w_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  line_evt_t         evt,
    input  logic [TADR_W-1:0] dev_addr,
    input  logic [HDR_W-1:0]  reg_rdata,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [HDR_W-1:0]  reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              drive_en,
    output logic              drive_val
);

    localparam int               CNT_W   = $clog2(HDR_W + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HDR_W);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    link_state_e      st_q, st_d;
    logic [CNT_W-1:0] bitn_q, bitn_d;
    logic [HDR_W-1:0] rx_q, rx_d;
    logic [HDR_W-1:0] tx_q, tx_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             rw_q, rw_d;
    logic             first_q, first_d;
    logic             nack_q, nack_d;
    logic             drv_q, drv_d;
    logic             bit_q, bit_d;
    logic             byte_done;
    logic             load_rd;
    logic             store_wr;

    assign byte_done = (bitn_q == CNT_END);

    always_comb begin
        st_d     = st_q;
        bitn_d   = bitn_q;
        rx_d     = rx_q;
        tx_d     = tx_q;
        ptr_d    = ptr_q;
        rw_d     = rw_q;
        first_d  = first_q;
        nack_d   = nack_q;
        drv_d    = drv_q;
        bit_d    = bit_q;
        load_rd  = 1'b0;
        store_wr = 1'b0;

        if (evt.start) begin
            st_d   = ST_ADDR;
            bitn_d = '0;
            drv_d  = 1'b0;
        end else if (evt.stop) begin
            st_d   = ST_IDLE;
            bitn_d = '0;
            drv_d  = 1'b0;
        end else if (evt.scl_rise) begin
            case (st_q)
                ST_ADDR, ST_WR_DATA: begin
                    rx_d   = {rx_q[HDR_W-2:0], evt.sda};
                    bitn_d = bitn_q + 1'b1;
                end
                ST_RD_DATA: bitn_d = bitn_q + 1'b1;
                ST_RD_ACK:  nack_d = evt.sda;
                default: ;
            endcase
        end else if (evt.scl_fall) begin
            case (st_q)
                ST_ADDR: begin
                    if (byte_done) begin
                        if (addr_hit(rx_q, dev_addr)) begin
                            st_d  = ST_ADDR_ACK;
                            rw_d  = hdr_is_read(rx_q);
                            drv_d = 1'b1;
                            bit_d = 1'b0;
                        end else begin
                            st_d = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    bitn_d = '0;
                    if (rw_q) begin
                        st_d    = ST_RD_DATA;
                        load_rd = 1'b1;
                    end else begin
                        st_d    = ST_WR_DATA;
                        first_d = 1'b1;
                        drv_d   = 1'b0;
                    end
                end
                ST_WR_DATA: begin
                    if (byte_done) begin
                        st_d  = ST_WR_ACK;
                        drv_d = 1'b1;
                        bit_d = 1'b0;
                        if (first_q) begin
                            ptr_d   = rx_q[PTR_W-1:0];
                            first_d = 1'b0;
                        end else begin
                            store_wr = 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    st_d   = ST_WR_DATA;
                    drv_d  = 1'b0;
                    bitn_d = '0;
                end
                ST_RD_DATA: begin
                    if (byte_done) begin
                        st_d  = ST_RD_ACK;
                        drv_d = 1'b0;
                    end else begin
                        bit_d = tx_q[HDR_W-1];
                        tx_d  = {tx_q[HDR_W-2:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    if (nack_q) begin
                        st_d = ST_IGNORE;
                    end else begin
                        st_d    = ST_RD_DATA;
                        bitn_d  = '0;
                        load_rd = 1'b1;
                    end
                end
                default: ;
            endcase

            if (load_rd) begin
                bit_d = reg_rdata[HDR_W-1];
                tx_d  = {reg_rdata[HDR_W-2:0], 1'b0};
                drv_d = 1'b1;
                ptr_d = ptr_q + PTR_ONE;
            end
            if (store_wr) begin
                ptr_d = ptr_q + PTR_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            bitn_q  <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            nack_q  <= 1'b0;
            drv_q   <= 1'b0;
            bit_q   <= 1'b1;
        end else begin
            st_q    <= st_d;
            bitn_q  <= bitn_d;
            rx_q    <= rx_d;
            tx_q    <= tx_d;
            ptr_q   <= ptr_d;
            rw_q    <= rw_d;
            first_q <= first_d;
            nack_q  <= nack_d;
            drv_q   <= drv_d;
            bit_q   <= bit_d;
        end
    end

    assign reg_addr  = ptr_q;
    assign reg_wdata = rx_q;
    assign reg_wr    = store_wr;
    assign reg_rd    = load_rd;
    assign drive_en  = drv_q;
    assign drive_val = bit_q;

endmodule

// File: rtl/pp2w_sda_drv.sv
module pp2w_sda_drv (
    input  logic clk,
    input  logic rst,
    input  logic drive_en,
    input  logic drive_val,
    input  logic scl_lvl,
    input  logic scl_prev,
    output logic sda_oe,
    output logic sda_o
);

    logic oe;
    logic keep_q;

    // Drive only when the clock has been low for two consecutive samples
    assign oe = drive_en & ~scl_lvl & ~scl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q <= 1'b1;
        end else if (oe) begin
            keep_q <= drive_val;
        end
    end

    assign sda_oe = oe;
    assign sda_o  = oe ? drive_val : keep_q;

endmodule

// File: rtl/pp2w_target.sv
module pp2w_target
    import pp2w_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PTR_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [TADR_W-1:0] dev_addr,
    output logic              sda_oe,
    output logic              sda_o,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [HDR_W-1:0]  reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [HDR_W-1:0]  reg_rdata
);

    line_evt_t line_evt;
    logic      scl_sync;
    logic      scl_sync_prev;
    logic      drive_en;
    logic      drive_val;
    logic      stop_seen;

    pp2w_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .evt     (line_evt),
        .scl_lvl (scl_sync),
        .scl_prev(scl_sync_prev)
    );

    pp2w_proto #(
        .PTR_W(PTR_W)
    ) i_proto (
        .clk      (clk),
        .rst      (rst),
        .evt      (line_evt),
        .dev_addr (dev_addr),
        .reg_rdata(reg_rdata),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .drive_en (drive_en),
        .drive_val(drive_val)
    );

    pp2w_sda_drv i_drv (
        .clk      (clk),
        .rst      (rst),
        .drive_en (drive_en),
        .drive_val(drive_val),
        .scl_lvl  (scl_sync),
        .scl_prev (scl_sync_prev),
        .sda_oe   (sda_oe),
        .sda_o    (sda_o)
    );

    assign stop_seen = line_evt.stop;

endmodule

// File: rtl/pp2w_target_chk.sv
module pp2w_target_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sda_oe,
    input logic             sda_o,
    input logic             scl_sync,
    input logic             stop_seen,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [PTR_W-1:0] reg_addr
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_oe && !reg_wr && !reg_rd));

    p_stop_release_r2: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_oe);

    p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> !scl_sync);

    p_wr_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

    p_rd_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_wr, reg_rd}));

    p_keeper_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !sda_oe |-> $stable(sda_o));

endmodule

bind pp2w_target pp2w_target_chk #(
    .PTR_W(PTR_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .sda_o    (sda_o),
    .scl_sync (scl_sync),
    .stop_seen(stop_seen),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr)
);

// File: tb/test_pp2w_target.sv
module test_pp2w_target;

    localparam int         PTR_W    = 8;
    localparam logic [6:0] OWN_ADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // Controller side and line with keeper
    logic scl    = 1'b1;
    logic ctl_oe = 1'b1;
    logic ctl_o  = 1'b1;
    logic line   = 1'b1;

    logic             sda_oe, sda_o, reg_wr, reg_rd;
    logic [PTR_W-1:0] reg_addr;
    logic [7:0]       reg_wdata, reg_rdata;

    always @(ctl_oe or ctl_o or sda_oe or sda_o) begin
        if (ctl_oe)      line = ctl_o;
        else if (sda_oe) line = sda_o;
    end

    pp2w_target i_pp2w_target (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(line), .dev_addr(OWN_ADDR),
        .sda_oe(sda_oe), .sda_o(sda_o), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // Register file attached to the strobe port
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int wr_cnt = 0;
    int rd_cnt = 0;

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
        end else begin
            if (reg_wr) begin
                mem[reg_addr] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd) rd_cnt <= rd_cnt + 1;
        end
    end

    // Line-discipline monitor
    int hi_cnt = 0;
    int clash_cnt = 0;
    int hi_drive_cnt = 0;
    always @(posedge clk) hi_cnt <= scl ? hi_cnt + 1 : 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ctl_oe && sda_oe) clash_cnt++;
            if (sda_oe && scl && hi_cnt >= 2) hi_drive_cnt++;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    logic last_keep;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cond();
        if (!scl) begin
            wait_n(4); ctl_oe = 1'b1; ctl_o = 1'b1;
            wait_n(8); scl = 1'b1;
            wait_n(8);
        end else begin
            ctl_oe = 1'b1; ctl_o = 1'b1;
            wait_n(8);
        end
        ctl_o = 1'b0;
        wait_n(8); scl = 1'b0;
    endtask

    task automatic stop_cond();
        wait_n(4); ctl_oe = 1'b1; ctl_o = 1'b0;
        wait_n(8); scl = 1'b1;
        wait_n(8); ctl_o = 1'b1;
        wait_n(16);
        chk(sda_oe == 1'b0, "R2", "enable after stop", int'(sda_oe), 0);
    endtask

    task automatic send_bit(input logic b);
        wait_n(4); ctl_oe = 1'b1; ctl_o = b;
        wait_n(8); ctl_oe = 1'b0;
        wait_n(4); scl = 1'b1;
        wait_n(16); scl = 1'b0;
    endtask

    task automatic recv_bit(input bit timed, output logic oe_seen, output logic val);
        ctl_oe = 1'b0;
        if (timed) begin
            wait_n(2);
            chk(sda_oe == 1'b0, "R11", "enable two clocks after fall", int'(sda_oe), 0);
            wait_n(1);
            chk(sda_oe == 1'b1, "R11", "enable three clocks after fall", int'(sda_oe), 1);
            wait_n(5);
        end else begin
            wait_n(8);
        end
        oe_seen = sda_oe;
        wait_n(8); scl = 1'b1;
        if (timed) begin
            wait_n(1);
            chk(sda_oe == 1'b1, "R3", "enable one clock after rise", int'(sda_oe), 1);
            wait_n(1);
            chk(sda_oe == 1'b0, "R3", "enable two clocks after rise", int'(sda_oe), 0);
            wait_n(6);
        end else begin
            wait_n(8);
        end
        val = line;
        last_keep = sda_o;
        wait_n(8); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit timed, output bit ack);
        logic oe_seen, v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(timed, oe_seen, v);
        ack = oe_seen && (v == 1'b0);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic oe_seen, v;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(1'b0, oe_seen, v);
            b = {b[6:0], v};
        end
        send_bit(give_ack ? 1'b0 : 1'b1);
    endtask

    task automatic wr_burst(input logic [7:0] p, input int n, input logic [7:0] seed);
        bit ack;
        int wr_base;
        start_cond();
        send_byte({OWN_ADDR, 1'b0}, 1'b0, ack);
        chk(ack, "R4", "write header ack", int'(ack), 1);
        wr_base = wr_cnt;
        send_byte(p, 1'b0, ack);
        chk(ack, "R6", "pointer byte ack", int'(ack), 1);
        chk(wr_cnt == wr_base, "R6", "strobes after pointer byte", wr_cnt - wr_base, 0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'(int'(p) * 3 + i * 29 + int'(seed));
            send_byte(d, 1'b0, ack);
            chk(ack, "R7", "data byte ack", int'(ack), 1);
            exp_mem[8'(p + 8'(i))] = d;
        end
        stop_cond();
        chk(wr_cnt - wr_base == n, "R7", "write strobe count", wr_cnt - wr_base, n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            a = 8'(p + 8'(i));
            chk(mem[a] == exp_mem[a], "R7", "stored byte", int'(mem[a]), int'(exp_mem[a]));
        end
    endtask

    task automatic rd_burst(input logic [7:0] p, input int n);
        bit ack;
        int rd_base;
        logic [7:0] b;
        logic oe_seen, v;
        start_cond();
        send_byte({OWN_ADDR, 1'b0}, 1'b0, ack);
        chk(ack, "R4", "header ack before pointer", int'(ack), 1);
        send_byte(p, 1'b0, ack);
        chk(ack, "R6", "pointer ack", int'(ack), 1);
        start_cond();
        send_byte({OWN_ADDR, 1'b1}, 1'b0, ack);
        chk(ack, "R10", "read header after repeated start", int'(ack), 1);
        rd_base = rd_cnt;
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            a = 8'(p + 8'(i));
            recv_byte(i < n - 1, b);
            chk(b == exp_mem[a], "R8", "read byte", int'(b), int'(exp_mem[a]));
        end
        recv_bit(1'b0, oe_seen, v);
        chk(oe_seen == 1'b0, "R9", "enable after refused ack", int'(oe_seen), 0);
        stop_cond();
        chk(rd_cnt - rd_base == n, "R8", "fetch strobe count", rd_cnt - rd_base, n);
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 37 + 5);

        wait_n(5);
        chk(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R1", "outputs in reset",
            int'({sda_oe, reg_wr, reg_rd}), 0);
        rst = 1'b0;
        wait_n(1);
        chk(sda_oe == 1'b0, "R1", "enable after reset", int'(sda_oe), 0);
        chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R1", "strobes after reset",
            int'({reg_wr, reg_rd}), 0);
        chk(sda_o == 1'b1, "R12", "kept level after reset", int'(sda_o), 1);
        wait_n(20);

        // Address sweep: only the configured address is acknowledged
        for (int a = 0; a < 128; a++) begin
            bit own;
            own = (7'(a) == OWN_ADDR);
            start_cond();
            send_byte({7'(a), 1'b0}, own, ack);
            chk(ack == own, own ? "R4" : "R5", "address ack", int'(ack), int'(own));
            if (own) chk(last_keep == 1'b0, "R12", "kept ack level", int'(last_keep), 0);
            stop_cond();
        end
        chk(wr_cnt == 0 && rd_cnt == 0, "R5", "strobes during sweep", wr_cnt + rd_cnt, 0);

        // Read header to a neighbour address is refused too
        start_cond();
        send_byte({OWN_ADDR ^ 7'h40, 1'b1}, 1'b0, ack);
        chk(!ack, "R5", "read header to other address", int'(ack), 0);
        stop_cond();

        // Data after a refused header is ignored
        start_cond();
        send_byte({OWN_ADDR ^ 7'h01, 1'b0}, 1'b0, ack);
        chk(!ack, "R5", "mismatch header", int'(ack), 0);
        send_byte(8'h20, 1'b0, ack);
        chk(!ack, "R5", "ignored pointer byte", int'(ack), 0);
        send_byte(8'h77, 1'b0, ack);
        chk(!ack, "R5", "ignored data byte", int'(ack), 0);
        stop_cond();
        chk(wr_cnt == 0, "R5", "no store after mismatch", wr_cnt, 0);
        chk(mem[8'h20] == exp_mem[8'h20], "R5", "untouched byte",
            int'(mem[8'h20]), int'(exp_mem[8'h20]));

        // Stop in the middle of an address byte, then a clean transfer
        start_cond();
        for (int i = 0; i < 4; i++) send_bit(OWN_ADDR[6 - i]);
        stop_cond();
        start_cond();
        send_byte({OWN_ADDR, 1'b0}, 1'b0, ack);
        chk(ack, "R2", "ack after aborted byte", int'(ack), 1);
        stop_cond();

        // Write bursts, including one across the pointer wrap
        wr_burst(8'h10, 4, 8'h11);
        wr_burst(8'hFE, 4, 8'h40);
        wr_burst(8'h80, 1, 8'h9C);

        // Read bursts with repeated start
        rd_burst(8'h10, 4);
        rd_burst(8'hFE, 4);
        rd_burst(8'h40, 3);

        // Pointer kept across the stop: next read starts at 0x43
        start_cond();
        send_byte({OWN_ADDR, 1'b1}, 1'b0, ack);
        chk(ack, "R10", "read header without pointer", int'(ack), 1);
        recv_byte(1'b1, b);
        chk(b == exp_mem[8'h43], "R10", "byte at kept pointer", int'(b), int'(exp_mem[8'h43]));
        recv_byte(1'b0, b);
        chk(b == exp_mem[8'h44], "R10", "next byte at kept pointer", int'(b), int'(exp_mem[8'h44]));
        stop_cond();

        chk(clash_cnt == 0, "R3", "cycles with both drivers on", clash_cnt, 0);
        chk(hi_drive_cnt == 0, "R3", "cycles driven with clock high", hi_drive_cnt, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual 0x1 expected 0x0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule